// File: doc/BRIEF.md
# Dwell-Count Sequenced Pattern Generator

This block is a clocked stimulus source. It holds a small table, and each row of that table pairs an output word with a hold count in clock cycles. After reset is released, the block steps through the rows in order. It keeps each row's word on a registered parallel bus for that row's number of cycles, then moves on to the next row.

The table is filled through a simple write port while reset is held. A mode input picks one of two run types. In the single-pass run, the bus freezes on the last row's word and a done flag is raised. In the loop run, the sequence returns to the first row with no gap, so the output is periodic and its period is the sum of all the hold counts.

A cycle index is used below to state timing. Cycle 0 is the interval that follows the last rising edge at which reset was sampled high. Cycle k is the interval that follows the k-th rising edge at which reset is sampled low.

Top module: `dwell_seq_gen`

## Requirements
- R1: While `rst` is high, the row index returns to 0 and `done` is low. At every edge in reset, `patOut` is loaded with the word stored in row 0.
- R2: A table write (`wrEn` high, row `wrAddr`) takes effect only at an edge where `rst` is high. A write presented while `rst` is low changes neither the table nor the output.
- R3: After release, the rows appear in table order starting from row 0. Row i's word is on `patOut` for exactly its effective count of consecutive cycles, so row 0 covers cycles 0 to c0-1.
- R4: A row whose stored count is 0 behaves as a count of 1.
- R5: `numEntries` sets how many rows are used. A value of 0 is taken as 1, and a value above the table depth is taken as the depth.
- R6: With `loopMode` high, the row after the last used row is row 0, with no idle cycle in between. The period is the sum of the effective counts, and `done` stays low.
- R7: With `loopMode` low, let T be the sum of the effective counts. From cycle T onward, `patOut` keeps the last used row's word and `done` is high. `done` stays high until the next reset.
- R8: The pattern 0x0F held for 13 cycles, then 0x0A for 4, then 0x0C for 1 is reproduced exactly, both in a single pass and in loop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; also the table write window |
| loopMode | input | 1 | 1 = repeat the pattern, 0 = run once and stop |
| numEntries | input | IDX_W+1 | Number of table rows in use |
| wrEn | input | 1 | Table write strobe |
| wrAddr | input | IDX_W | Row written |
| wrWord | input | WORD_W | Output word for the written row |
| wrCount | input | CNT_W | Hold count for the written row |
| patOut | output | WORD_W | Registered pattern output |
| done | output | 1 | Single-pass run has finished |

## Verification
The embedded assertions check these properties on every cycle:
- the row index stays inside the used range and does not move while the dwell counter is nonzero;
- the output changes only on an advance strobe;
- writes made outside reset leave the table untouched;
- `done` is sticky, appears only on the last row in single-pass mode, and never appears in loop mode.

Exact hold lengths, the zero-count rule, the clamping of the row count, and the gap-free wrap can only be shown by the bench's scenarios. The bench compares the output in every cycle against a timeline computed from the programmed counts.

// File: rtl/dwell_seq_pkg.sv
package dwell_seq_pkg;
  typedef struct packed {
    logic reload;   // reset: point at row 0 and load its word
    logic advance;  // dwell expired: move to the next row
  } seqStrobe_t;
endpackage

// File: rtl/dwell_seq_ctrl.sv
module dwell_seq_ctrl
  import dwell_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loopMode,
  input  logic [IDX_W:0]   numEntries,
  input  logic [CNT_W-1:0] selCount,
  output logic [IDX_W-1:0] selIdx,
  output seqStrobe_t       strobe,
  output logic             done
);
  logic [IDX_W-1:0] idx, lastIdx, nextIdx;
  logic [CNT_W-1:0] dwellLeft, loadVal;
  logic expire, atEnd;

  always_comb begin
    if (numEntries == '0)
      lastIdx = '0;
    else if (numEntries > (IDX_W+1)'(DEPTH))
      lastIdx = IDX_W'(DEPTH - 1);
    else
      lastIdx = IDX_W'(numEntries - 1'b1);
  end

  assign expire  = (dwellLeft == '0);
  assign atEnd   = (idx == lastIdx);
  assign nextIdx = atEnd ? '0 : idx + 1'b1;
  assign selIdx  = rst ? '0 : nextIdx;
  assign loadVal = (selCount == '0) ? '0 : selCount - 1'b1;

  always_comb begin
    strobe.reload  = rst;
    strobe.advance = !rst && !done && expire && (loopMode || !atEnd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      dwellLeft <= loadVal;
      done      <= 1'b0;
    end else if (strobe.advance) begin
      idx       <= nextIdx;
      dwellLeft <= loadVal;
    end else if (expire) begin
      if (atEnd && !loopMode) done <= 1'b1;
    end else begin
      dwellLeft <= dwellLeft - 1'b1;
    end
  end

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    idx <= lastIdx);
  // R3
  hold_row_chk: assert property (@(posedge clk) disable iff (rst)
    (dwellLeft != '0) |=> $stable(idx));
  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  // R7
  done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (idx == lastIdx));
  // R6
  loop_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    (loopMode && !done) |=> !done);
endmodule

// File: rtl/dwell_seq_data.sv
module dwell_seq_data
  import dwell_seq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 8,
  parameter int CNT_W  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [WORD_W-1:0] wrWord,
  input  logic [CNT_W-1:0]  wrCount,
  input  seqStrobe_t        strobe,
  input  logic [IDX_W-1:0]  selIdx,
  output logic [CNT_W-1:0]  selCount,
  output logic [WORD_W-1:0] patOut
);
  logic [WORD_W-1:0] wordMem  [DEPTH];
  logic [CNT_W-1:0]  countMem [DEPTH];
  logic [WORD_W-1:0] selWord;

  always_ff @(posedge clk) begin
    if (rst && wrEn && (int'(wrAddr) < DEPTH)) begin
      wordMem[wrAddr]  <= wrWord;
      countMem[wrAddr] <= wrCount;
    end
  end

  assign selWord  = wordMem[selIdx];
  assign selCount = countMem[selIdx];

  always_ff @(posedge clk) begin
    if (strobe.reload || strobe.advance)
      patOut <= selWord;
  end

  // R1
  reset_load_chk: assert property (@(posedge clk)
    rst |=> (patOut == $past(wordMem[0])));
  // R2
  write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> (wordMem[$past(wrAddr)] == $past(wordMem[wrAddr])));
  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.advance |=> $stable(patOut));
endmodule

// File: rtl/dwell_seq_gen.sv
module dwell_seq_gen
  import dwell_seq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 8,
  parameter int CNT_W  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loopMode,
  input  logic [IDX_W:0]    numEntries,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [WORD_W-1:0] wrWord,
  input  logic [CNT_W-1:0]  wrCount,
  output logic [WORD_W-1:0] patOut,
  output logic              done
);
  seqStrobe_t       strobe;
  logic [IDX_W-1:0] selIdx;
  logic [CNT_W-1:0] selCount;

  dwell_seq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .loopMode(loopMode), .numEntries(numEntries),
    .selCount(selCount), .selIdx(selIdx), .strobe(strobe), .done(done)
  );

  dwell_seq_data #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrWord(wrWord),
    .wrCount(wrCount), .strobe(strobe), .selIdx(selIdx),
    .selCount(selCount), .patOut(patOut)
  );
endmodule

// File: tb/dwell_seq_gen_bench.sv
module dwell_seq_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       loopMode = 1'b0;
  logic [4:0] numEntries = 5'd1;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrWord = '0;
  logic [15:0] wrCount = '0;
  logic [7:0] patOut;
  logic       done;

  int checks = 0;
  int fails = 0;
  int tWord [16];
  int tCnt  [16];

  always #2 clk = ~clk;

  dwell_seq_gen u_dwell_seq_gen (
    .clk(clk), .rst(rst), .loopMode(loopMode), .numEntries(numEntries),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrWord(wrWord), .wrCount(wrCount),
    .patOut(patOut), .done(done)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int usedRows();
    if (numEntries == 0) return 1;
    if (numEntries > 16) return 16;
    return int'(numEntries);
  endfunction

  // Expected word and done flag for cycle k, from the requirement timeline
  task automatic expectAt(int k, bit lp, output int w, output int d);
    int n = usedRows();
    int tot = 0;
    int kk;
    for (int i = 0; i < n; i++) tot += (tCnt[i] == 0) ? 1 : tCnt[i];
    d = 0;
    if (!lp && k >= tot) begin
      w = tWord[n-1];
      d = 1;
      return;
    end
    kk = lp ? (k % tot) : k;
    w = tWord[0];
    for (int i = 0; i < n; i++) begin
      int e = (tCnt[i] == 0) ? 1 : tCnt[i];
      if (kk < e) begin
        w = tWord[i];
        return;
      end
      kk -= e;
    end
  endtask

  // Fill all 16 rows while reset is high, then check the reset state (R1)
  task automatic loadTable();
    rst = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      wrEn = 1'b1;
      wrAddr = 4'(i);
      wrWord = 8'(tWord[i]);
      wrCount = 16'(tCnt[i]);
    end
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset word", int'(patOut), tWord[0]);
    check("R1 reset done", int'(done), 0);
  endtask

  // Release reset and compare every cycle; junk writes run throughout (R2)
  task automatic runFor(bit lp, int cycles, string tag);
    int w, d;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      if (k > 0) @(negedge clk);
      expectAt(k, lp, w, d);
      check({tag, " R2 R3 word"}, int'(patOut), w);
      check({tag, " done"}, int'(done), d);
      wrEn = 1'b1;
      wrAddr = 4'(k);
      wrWord = 8'(8'hE7 ^ k[7:0]);
      wrCount = 16'd7;
    end
    @(negedge clk);
    wrEn = 1'b0;
    rst = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      tWord[i] = 8'hC0 + i;
      tCnt[i] = 2;
    end
    // R8 worked pattern, single pass (R7) then looped (R6)
    tWord[0] = 8'h0F; tCnt[0] = 13;
    tWord[1] = 8'h0A; tCnt[1] = 4;
    tWord[2] = 8'h0C; tCnt[2] = 1;
    numEntries = 5'd3;
    loopMode = 1'b0;
    loadTable();
    runFor(1'b0, 24, "R8 R7 single");
    loopMode = 1'b1;
    loadTable();
    runFor(1'b1, 45, "R8 R6 loop");

    // R4 zero counts mixed with others
    tWord[0] = 8'h11; tCnt[0] = 0;
    tWord[1] = 8'h22; tCnt[1] = 2;
    tWord[2] = 8'h33; tCnt[2] = 0;
    tWord[3] = 8'h44; tCnt[3] = 3;
    tWord[4] = 8'h55; tCnt[4] = 1;
    numEntries = 5'd5;
    loopMode = 1'b1;
    loadTable();
    runFor(1'b1, 30, "R4 loop");
    loopMode = 1'b0;
    loadTable();
    runFor(1'b0, 12, "R4 R7 single");

    // R5 zero row count means one row
    tWord[0] = 8'hA5; tCnt[0] = 3;
    numEntries = 5'd0;
    loopMode = 1'b0;
    loadTable();
    runFor(1'b0, 6, "R5 zero single");
    loopMode = 1'b1;
    loadTable();
    runFor(1'b1, 6, "R5 zero loop");

    // R5 clamp above depth: full table, counts 0,1,2 repeating
    for (int i = 0; i < 16; i++) begin
      tWord[i] = (i * 17) & 8'hFF;
      tCnt[i] = i % 3;
    end
    numEntries = 5'd20;
    loopMode = 1'b1;
    loadTable();
    runFor(1'b1, 70, "R5 clamp loop");
    loopMode = 1'b0;
    loadTable();
    runFor(1'b0, 35, "R5 R7 clamp single");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule